// File: doc/BRIEF.md
# Temperature-Driven Fan Duty Curve with Hysteresis

This block turns a stream of temperature samples into a fan drive level. Four programmable temperature set points divide the range into five bands. The lowest band uses a minimum non-stop duty. Each set point brings in its own duty code once the temperature has climbed past it. A shared tolerance widens every set point into a band. A rising temperature must reach the point plus the tolerance before the fan steps up. A falling temperature must reach the point minus the tolerance before it steps down. This stops the fan from hunting when the temperature sits close to a set point.

The current band is kept as a level index from 0 to 4. It moves by at most one step for each valid sample. A critical threshold sits above the whole curve: any sample hotter than it drives the duty to full scale. The default threshold of 127 can never be exceeded by a signed 8-bit reading, so by default this override is off. The selected duty code is also turned into a PWM waveform by a free-running counter. Temperatures are signed two's-complement degrees. The set points must be programmed in ascending order.

Top module: `fan_curve`

## Requirements
- R1: After reset the level index is 0 and duty_o equals duty_min_i.
- R2: On a valid sample at level k (k < 4), the level rises to k+1 only if the temperature is greater than or equal to point k plus the tolerance. Point k is field k of pt_i, bits [8k+7:8k], with point 0 the lowest.
- R3: On a valid sample at level k (k > 0), the level falls to k-1 only if the temperature is less than or equal to point k-1 minus the tolerance.
- R4: A valid sample whose temperature lies strictly between the falling threshold and the rising threshold of the current level leaves the level unchanged.
- R5: A single valid sample changes the level by at most one step, however far the temperature lies from the current band.
- R6: Without a valid strobe, the level and the critical state do not change.
- R7: At level 0, duty_o equals duty_min_i. At level k (1 to 4), duty_o equals field k-1 of duty_pt_i, bits [8k-1:8k-8]. Level 4 is the ceiling.
- R8: A valid sample with temperature strictly greater than crit_i (signed) forces duty_o to 0xFF. A sample equal to or below crit_i releases the override, and the curve level is tracked throughout.
- R9: With crit_i at 127, no sample forces full scale.
- R10: pwm_o is high for exactly duty_o cycles out of every 256. It is never high when duty_o is 0x00 and always high when duty_o is 0xFF.
- R11: duty_o reflects a sample from the clock edge that captures temp_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_valid_i | input | 1 | Temperature sample strobe |
| temp_i | input | 8 | Signed temperature sample |
| pt_i | input | 32 | Four signed set points, point 0 in the low byte |
| duty_pt_i | input | 32 | Four duty codes, one per set point, low byte first |
| duty_min_i | input | 8 | Duty code for the lowest band |
| tol_i | input | 8 | Unsigned hysteresis tolerance |
| crit_i | input | 8 | Signed critical threshold |
| duty_o | output | 8 | Selected duty code |
| pwm_o | output | 1 | PWM waveform, 256-cycle period |

## Verification
The assertions check on every cycle that the level stays in range and moves by at most one step. They also check that it holds without a strobe, that an over-critical sample gives full scale on the next cycle, and that the PWM output matches the 0x00 and 0xFF duty extremes. Only the bench scenarios can show where the hysteresis thresholds fall exactly: the equality cases at point plus tolerance and point minus tolerance, and the hold inside the dead band. The bench scenarios also cover the release of the override at a sample equal to the threshold and the exact PWM high-time for intermediate duty codes.

// File: rtl/fan_curve_pkg.sv
`timescale 1ns/1ps
package fan_curve_pkg;
  typedef enum logic [1:0] {
    MV_HOLD = 2'd0,
    MV_UP   = 2'd1,
    MV_DOWN = 2'd2
  } move_e;
endpackage

// File: rtl/fan_curve_track.sv
`timescale 1ns/1ps
module fan_curve_track
  import fan_curve_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int NPTS   = 4,
  localparam int LVL_W = $clog2(NPTS + 1),
  localparam int IDX_W = $clog2(NPTS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [TEMP_W-1:0]        temp_i,
  input  logic [NPTS*TEMP_W-1:0]   pt_i,
  input  logic [TEMP_W-1:0]        tol_i,
  input  logic [TEMP_W-1:0]        crit_i,
  output logic [LVL_W-1:0]         lvl_o,
  output logic                     hot_o
);
  localparam int EXT_W = TEMP_W + 2;

  logic [TEMP_W-1:0] pt_a [NPTS];
  for (genvar k = 0; k < NPTS; k++) begin : g_pt
    assign pt_a[k] = pt_i[k*TEMP_W +: TEMP_W];
  end

  logic [LVL_W-1:0] lvl_q;
  logic             hot_q;
  logic [IDX_W-1:0] up_idx, dn_idx;
  logic [TEMP_W-1:0] p_up, p_dn;
  logic signed [EXT_W-1:0] t_x, up_th, dn_th, tol_x;
  move_e mv;

  assign up_idx = (lvl_q < LVL_W'(NPTS)) ? IDX_W'(lvl_q) : '0;
  assign dn_idx = (lvl_q != '0) ? IDX_W'(lvl_q - LVL_W'(1)) : '0;
  assign p_up   = pt_a[up_idx];
  assign p_dn   = pt_a[dn_idx];

  // widened so point +/- tolerance never wraps
  assign t_x   = {{2{temp_i[TEMP_W-1]}}, temp_i};
  assign tol_x = {2'b00, tol_i};
  assign up_th = $signed({{2{p_up[TEMP_W-1]}}, p_up}) + tol_x;
  assign dn_th = $signed({{2{p_dn[TEMP_W-1]}}, p_dn}) - tol_x;

  always_comb begin
    mv = MV_HOLD;
    if (lvl_q < LVL_W'(NPTS) && t_x >= up_th)  mv = MV_UP;
    else if (lvl_q != '0 && t_x <= dn_th)      mv = MV_DOWN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      hot_q <= 1'b0;
    end else if (valid_i) begin
      hot_q <= $signed(temp_i) > $signed(crit_i);
      case (mv)
        MV_UP:   lvl_q <= lvl_q + LVL_W'(1);
        MV_DOWN: lvl_q <= lvl_q - LVL_W'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  assign lvl_o = lvl_q;
  assign hot_o = hot_q;
endmodule

// File: rtl/fan_curve_sel.sv
`timescale 1ns/1ps
module fan_curve_sel #(
  parameter int DUTY_W = 8,
  parameter int NPTS   = 4,
  localparam int LVL_W = $clog2(NPTS + 1),
  localparam int IDX_W = $clog2(NPTS)
) (
  input  logic [LVL_W-1:0]       lvl_i,
  input  logic                   hot_i,
  input  logic [NPTS*DUTY_W-1:0] duty_pt_i,
  input  logic [DUTY_W-1:0]      duty_min_i,
  output logic [DUTY_W-1:0]      duty_o
);
  logic [DUTY_W-1:0] duty_a [NPTS];
  for (genvar k = 0; k < NPTS; k++) begin : g_duty
    assign duty_a[k] = duty_pt_i[k*DUTY_W +: DUTY_W];
  end

  always_comb begin
    if (hot_i)              duty_o = '1;
    else if (lvl_i == '0)   duty_o = duty_min_i;
    else                    duty_o = duty_a[IDX_W'(lvl_i - LVL_W'(1))];
  end
endmodule

// File: rtl/fan_curve_pwm.sv
`timescale 1ns/1ps
module fan_curve_pwm #(
  parameter int DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  logic [DUTY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + DUTY_W'(1);
  end

  // full-scale code holds the output high for the whole period
  assign pwm_o = (cnt_q < duty_i) || (&duty_i);
endmodule

// File: rtl/fan_curve.sv
`timescale 1ns/1ps
module fan_curve #(
  parameter int TEMP_W = 8,
  parameter int DUTY_W = 8,
  parameter int NPTS   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     temp_valid_i,
  input  logic [TEMP_W-1:0]        temp_i,
  input  logic [NPTS*TEMP_W-1:0]   pt_i,
  input  logic [NPTS*DUTY_W-1:0]   duty_pt_i,
  input  logic [DUTY_W-1:0]        duty_min_i,
  input  logic [TEMP_W-1:0]        tol_i,
  input  logic [TEMP_W-1:0]        crit_i,
  output logic [DUTY_W-1:0]        duty_o,
  output logic                     pwm_o
);
  localparam int LVL_W = $clog2(NPTS + 1);

  logic [LVL_W-1:0] lvl;
  logic             hot;

  fan_curve_track #(.TEMP_W(TEMP_W), .NPTS(NPTS)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (temp_valid_i),
    .temp_i  (temp_i),
    .pt_i    (pt_i),
    .tol_i   (tol_i),
    .crit_i  (crit_i),
    .lvl_o   (lvl),
    .hot_o   (hot)
  );

  fan_curve_sel #(.DUTY_W(DUTY_W), .NPTS(NPTS)) u_sel (
    .lvl_i      (lvl),
    .hot_i      (hot),
    .duty_pt_i  (duty_pt_i),
    .duty_min_i (duty_min_i),
    .duty_o     (duty_o)
  );

  fan_curve_pwm #(.DUTY_W(DUTY_W)) u_pwm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .duty_i (duty_o),
    .pwm_o  (pwm_o)
  );
endmodule

// File: rtl/fan_curve_chk.sv
`timescale 1ns/1ps
module fan_curve_chk #(
  parameter int TEMP_W = 8,
  parameter int DUTY_W = 8,
  parameter int NPTS   = 4,
  localparam int LVL_W = $clog2(NPTS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              temp_valid_i,
  input logic [TEMP_W-1:0] temp_i,
  input logic [TEMP_W-1:0] crit_i,
  input logic [DUTY_W-1:0] duty_o,
  input logic              pwm_o,
  input logic [LVL_W-1:0]  lvl_i,
  input logic              hot_i
);
  p_lvl_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i <= LVL_W'(NPTS));

  p_one_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (lvl_i == $past(lvl_i)) || (lvl_i == $past(lvl_i) + LVL_W'(1))
             || (lvl_i + LVL_W'(1) == $past(lvl_i)));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !temp_valid_i |=> $stable(lvl_i) && $stable(hot_i));

  p_crit_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_valid_i && ($signed(temp_i) > $signed(crit_i)) |=> (&duty_o));

  p_pwm_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&duty_o) |-> pwm_o);

  p_pwm_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_o == '0) |-> !pwm_o);
endmodule

bind fan_curve fan_curve_chk #(.TEMP_W(TEMP_W), .DUTY_W(DUTY_W), .NPTS(NPTS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .temp_valid_i (temp_valid_i),
  .temp_i       (temp_i),
  .crit_i       (crit_i),
  .duty_o       (duty_o),
  .pwm_o        (pwm_o),
  .lvl_i        (lvl),
  .hot_i        (hot)
);

// File: tb/tb_fan_curve.sv
`timescale 1ns/1ps
module tb_fan_curve;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  temp = 8'd0;
  logic [31:0] pt = {8'd60, 8'd50, 8'd40, 8'd30};
  logic [31:0] duty_pt = {8'hE0, 8'hB0, 8'h80, 8'h40};
  logic [7:0]  duty_min = 8'h20;
  logic [7:0]  tol = 8'd3;
  logic [7:0]  crit = 8'd127;
  logic [7:0]  duty;
  logic        pwm;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  fan_curve dut (
    .clk_i(clk), .rst_ni(rst_n), .temp_valid_i(valid), .temp_i(temp),
    .pt_i(pt), .duty_pt_i(duty_pt), .duty_min_i(duty_min), .tol_i(tol),
    .crit_i(crit), .duty_o(duty), .pwm_o(pwm)
  );

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: one-cycle strobe, expected duty queued for the monitor
  task automatic send(input logic [7:0] t, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    temp  = t;
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic count_high(output int n);
    n = 0;
    repeat (256) begin
      @(negedge clk);
      n += int'(pwm);
    end
  endtask

  // monitor: R11 result appears in the cycle after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      if (valid) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check(1, 0, "R11 unexpected sample");
        end else begin
          check(int'(duty), int'(exp_q.pop_front()), tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    check(int'(duty), 8'h20, "R1 reset duty");
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(duty), 8'h20, "R1 duty after release");

    send(8'd32,  8'h20, "R2 below point0+tol");
    send(8'd33,  8'h40, "R2 at point0+tol");
    send(8'd50,  8'h80, "R5 single step");
    send(8'd50,  8'h80, "R4 inside band");
    send(8'd53,  8'hB0, "R2 at point2+tol");
    send(8'd100, 8'hE0, "R2 top level");
    send(8'd100, 8'hE0, "R7 ceiling");
    send(8'd58,  8'hE0, "R4 above point3-tol");
    send(8'd57,  8'hB0, "R3 at point3-tol");
    send(8'd48,  8'hB0, "R4 above point2-tol");
    send(8'd47,  8'h80, "R3 at point2-tol");
    send(8'd0,   8'h40, "R5 single step down");
    send(8'hF6,  8'h20, "R3 to level 0");
    send(8'hF6,  8'h20, "R7 floor");

    settle();
    temp = 8'd100;
    repeat (20) @(negedge clk);
    check(int'(duty), 8'h20, "R6 no strobe");

    crit = 8'd80;
    send(8'd80, 8'h40, "R8 equal not forced");
    send(8'd81, 8'hFF, "R8 forced");
    send(8'd70, 8'hB0, "R8 released, level tracked");
    settle();
    crit = 8'd127;
    send(8'd127, 8'hE0, "R9 default threshold");

    settle();
    count_high(hi);
    check(hi, 224, "R10 duty 0xE0 high time");

    crit = 8'd0;
    send(8'd1, 8'hFF, "R8 forced low threshold");
    settle();
    count_high(hi);
    check(hi, 256, "R10 full scale");

    crit = 8'd127;
    duty_min = 8'h00;
    send(8'hCE, 8'h80, "R3 down to 2");
    send(8'hCE, 8'h40, "R3 down to 1");
    send(8'hCE, 8'h00, "R7 min duty zero");
    settle();
    count_high(hi);
    check(hi, 0, "R10 zero duty");
    check(exp_q.size(), 0, "R11 all samples seen");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule